// File: doc/BRIEF.md
# Two-Slope PI Converter Voltage Regulator

This block closes the voltage loop of a switching DC-to-DC converter in fixed-point hardware. Each time the sampling logic pulses its strobe (typically every 50 µs), the block takes a signed setpoint and the 12-bit digitised output voltage and forms their difference. It then applies a proportional term whose slope is steep near zero error and shallow further out. An integral term accumulates only while the error is small. The sum of the two terms is limited to the unit range and converted to an integer PWM pulse count of 0 to 240 for a downstream pulse generator.

All gains and band limits are signed Q4.12 words (value times 4096) applied on static inputs, so firmware or straps can retune the loop. The default tuning is a 0.256 inner slope, a 0.024 outer slope, a 0.4 proportional band, a 0.8 integration band, and an integral gain of 400 per second. At the 50 µs sample period that integral gain is 0.02 per sample, which is Q4.12 value 82. The integrator is held between 0 and 1, so it never winds up beyond what the output can express.

Top module: `npi_regulator`

## Requirements
- R1: The error is e = setpoint_i − 2·fb_code_i in Q4.12 units. The setpoint is signed Q4.12 and one ADC code is 1/2048.
- R2: When |e| ≤ band_p_i, the proportional term is P = round(k_in_i·e). Here round(x) means (x + 2048) >> 12 with an arithmetic shift on the raw Q4.12 product, that is, nearest with ties upward.
- R3: When |e| > band_p_i, the proportional term is P = round(k_out_i·e) + sgn(e)·round((k_in_i − k_out_i)·band_p_i).
- R4: When |e| ≤ band_i_i, the integrator adds round(ki_i·e) on each sample. Otherwise it keeps its value.
- R5: After each update the integrator is clamped to the range 0 to 4096, that is, 0.0 to 1.0.
- R6: Let u = P + I, where I includes this sample's update, saturated to 0..4096. Then count_o = (u·240 + 2048) >> 12, which always lies in 0..240.
- R7: count_vld_o is a one-cycle pulse in the third clock after the strobe cycle. count_o holds its value between pulses.
- R8: Reset clears the integrator, drives count_o to 0 and holds count_vld_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_vld_i | input | 1 | Sample strobe, one cycle per sample |
| setpoint_i | input | 16 | Signed Q4.12 voltage target |
| fb_code_i | input | 12 | Unsigned ADC code, 1/2048 per step |
| k_in_i | input | 16 | Signed Q4.12 inner proportional slope |
| k_out_i | input | 16 | Signed Q4.12 outer proportional slope |
| band_p_i | input | 16 | Signed Q4.12 proportional band limit |
| band_i_i | input | 16 | Signed Q4.12 integration band limit |
| ki_i | input | 16 | Signed Q4.12 integral gain per sample |
| count_o | output | 8 | PWM pulse count, 0..240 |
| count_vld_o | output | 1 | Count update pulse |

## Verification
Several properties are checked on every clock: the three-cycle strobe-to-valid delay, the stability of the count between updates, the 240 ceiling, the integrator's stay inside the unit range, and the integrator holding its value on out-of-band samples. The exact arithmetic can only be shown by the directed scenarios. These cover the inner and outer gain segments, rounding, saturation at both ends, integrator gating and clamping, and the effect of a mid-run reset. Each scenario reads the integrator back through a zero-error sample, where the count reflects the integrator alone.

// File: rtl/npi_pkg.sv
package npi_pkg;
  localparam int ACC_W = 40;
  typedef logic signed [ACC_W-1:0] acc_t;

  // round to nearest, ties up, dropping frac bits
  function automatic acc_t rnd_q(input acc_t x, input int frac);
    acc_t half;
    half = acc_t'(1) <<< (frac - 1);
    return (x + half) >>> frac;
  endfunction

  function automatic acc_t sat_q(input acc_t x, input acc_t lo, input acc_t hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction
endpackage

// File: rtl/npi_err_stage.sv
module npi_err_stage
  import npi_pkg::*;
#(
  parameter int DW      = 16,
  parameter int FRAC    = 12,
  parameter int ADC_W   = 12,
  parameter int ADC_LSB = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] sp_i,
  input  logic [ADC_W-1:0]     fb_i,
  input  logic signed [DW-1:0] band_p_i,
  input  logic signed [DW-1:0] band_i_i,
  output logic                 vld_o,
  output acc_t                 err_o,
  output logic                 in_p_o,
  output logic                 in_i_o
);
  localparam int SH = FRAC - ADC_LSB;

  acc_t err_d, mag_d;

  always_comb begin
    err_d = acc_t'(sp_i) - (acc_t'(fb_i) <<< SH);
    mag_d = (err_d < 0) ? -err_d : err_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      err_o  <= '0;
      in_p_o <= 1'b0;
      in_i_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        err_o  <= err_d;
        in_p_o <= mag_d <= acc_t'(band_p_i);
        in_i_o <= mag_d <= acc_t'(band_i_i);
      end
    end
  end
endmodule

// File: rtl/npi_prop_gain.sv
module npi_prop_gain
  import npi_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  acc_t                 err_i,
  input  logic                 in_p_i,
  input  logic signed [DW-1:0] k_in_i,
  input  logic signed [DW-1:0] k_out_i,
  input  logic signed [DW-1:0] band_p_i,
  output logic                 vld_o,
  output acc_t                 p_o
);
  acc_t p_d, bend;

  always_comb begin
    bend = rnd_q((acc_t'(k_in_i) - acc_t'(k_out_i)) * acc_t'(band_p_i), FRAC);
    if (in_p_i) p_d = rnd_q(acc_t'(k_in_i) * err_i, FRAC);
    else        p_d = rnd_q(acc_t'(k_out_i) * err_i, FRAC) + ((err_i < 0) ? -bend : bend);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      p_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) p_o <= p_d;
    end
  end
endmodule

// File: rtl/npi_integrator.sv
module npi_integrator
  import npi_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  acc_t                 err_i,
  input  logic                 in_i_i,
  input  logic signed [DW-1:0] ki_i,
  output acc_t                 integ_o
);
  localparam acc_t ONE = acc_t'(1) <<< FRAC;

  acc_t nxt;

  always_comb nxt = sat_q(integ_o + rnd_q(acc_t'(ki_i) * err_i, FRAC), '0, ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              integ_o <= '0;
    else if (vld_i && in_i_i) integ_o <= nxt;
  end

  a_r4_hold_outside_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !in_i_i) |=> $stable(integ_o));

  a_r5_integ_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ_o >= 0) && (integ_o <= ONE));
endmodule

// File: rtl/npi_regulator.sv
module npi_regulator
  import npi_pkg::*;
#(
  parameter int DW      = 16,
  parameter int FRAC    = 12,
  parameter int ADC_W   = 12,
  parameter int ADC_LSB = 11,
  parameter int PMAX    = 240,
  parameter int CW      = $clog2(PMAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_vld_i,
  input  logic signed [DW-1:0] setpoint_i,
  input  logic [ADC_W-1:0]     fb_code_i,
  input  logic signed [DW-1:0] k_in_i,
  input  logic signed [DW-1:0] k_out_i,
  input  logic signed [DW-1:0] band_p_i,
  input  logic signed [DW-1:0] band_i_i,
  input  logic signed [DW-1:0] ki_i,
  output logic [CW-1:0]        count_o,
  output logic                 count_vld_o
);
  localparam acc_t ONE = acc_t'(1) <<< FRAC;

  logic e_vld, in_p, in_i, p_vld;
  acc_t err, p_term, integ, u_sat, scaled;

  npi_err_stage #(.DW(DW), .FRAC(FRAC), .ADC_W(ADC_W), .ADC_LSB(ADC_LSB)) u_err (
    .clk_i, .rst_ni, .vld_i(sample_vld_i), .sp_i(setpoint_i), .fb_i(fb_code_i),
    .band_p_i, .band_i_i, .vld_o(e_vld), .err_o(err), .in_p_o(in_p), .in_i_o(in_i));

  npi_prop_gain #(.DW(DW), .FRAC(FRAC)) u_prop (
    .clk_i, .rst_ni, .vld_i(e_vld), .err_i(err), .in_p_i(in_p),
    .k_in_i, .k_out_i, .band_p_i, .vld_o(p_vld), .p_o(p_term));

  npi_integrator #(.DW(DW), .FRAC(FRAC)) u_int (
    .clk_i, .rst_ni, .vld_i(e_vld), .err_i(err), .in_i_i(in_i), .ki_i, .integ_o(integ));

  always_comb begin
    u_sat  = sat_q(p_term + integ, '0, ONE);
    scaled = rnd_q(u_sat * acc_t'(PMAX), FRAC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o     <= '0;
      count_vld_o <= 1'b0;
    end else begin
      count_vld_o <= p_vld;
      if (p_vld) count_o <= CW'(scaled);
    end
  end

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_vld_i |-> ##3 count_vld_o);

  a_r7_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_vld |=> $stable(count_o));

  a_r6_count_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(PMAX));
endmodule

// File: tb/tb_npi_regulator.sv
module tb_npi_regulator;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_vld = 1'b0;
  logic signed [15:0] sp = '0, k_in, k_out, band_p, band_i, ki;
  logic [11:0] fb = '0;
  logic [7:0] count;
  logic count_vld;
  int checks = 0, fails = 0;
  longint integ_m = 0;

  always #4 clk = ~clk;

  npi_regulator dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_vld_i(sample_vld), .setpoint_i(sp),
    .fb_code_i(fb), .k_in_i(k_in), .k_out_i(k_out), .band_p_i(band_p),
    .band_i_i(band_i), .ki_i(ki), .count_o(count), .count_vld_o(count_vld));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint rq(input longint x);
    return (x + 2048) >>> 12;
  endfunction

  function automatic longint clamp1(input longint x);
    if (x < 0) return 0;
    if (x > 4096) return 4096;
    return x;
  endfunction

  // model per R1..R6
  function automatic longint model(input int s, input int f);
    longint e, ae, p, u;
    e  = longint'(s) - 2 * longint'(f);
    ae = (e < 0) ? -e : e;
    if (ae <= band_p) p = rq(k_in * e);
    else p = rq(k_out * e) + ((e < 0) ? -rq((k_in - k_out) * band_p) : rq((k_in - k_out) * band_p));
    if (ae <= band_i) integ_m = clamp1(integ_m + rq(ki * e));
    u = clamp1(p + integ_m);
    return (u * 240 + 2048) >>> 12;
  endfunction

  task automatic do_sample(input int s, input int f, input string tag);
    longint exp_c;
    exp_c = model(s, f);
    @(negedge clk); sp = 16'(s); fb = 12'(f); sample_vld = 1'b1;
    @(negedge clk); sample_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(count_vld === 1'b1, {tag, " valid"}, longint'(count_vld), 1);
    chk(longint'(count) == exp_c, tag, longint'(count), exp_c);
  endtask

  task automatic set_gains(input int a, input int b, input int dp, input int di, input int g);
    k_in = 16'(a); k_out = 16'(b); band_p = 16'(dp); band_i = 16'(di); ki = 16'(g);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; integ_m = 0;
    @(negedge clk);
    chk(count == 0, "R8 reset count", longint'(count), 0);
    chk(count_vld == 0, "R8 reset valid", longint'(count_vld), 0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic t_inner();
    set_gains(1049, 98, 1638, 3277, 0);
    do_sample(2048, 1000, "R1 R2 inner e=48");
    do_sample(2048, 900, "R2 inner e=248 rounding");
    do_sample(3000, 1200, "R2 inner e=600");
  endtask

  task automatic t_outer();
    set_gains(1049, 98, 1638, 3277, 0);
    do_sample(6144, 0, "R3 outer e=6144");
    do_sample(8000, 100, "R3 outer e=7800");
  endtask

  task automatic t_saturate();
    set_gains(1049, 4096, 1638, 3277, 0);
    do_sample(8000, 0, "R6 upper saturation");
    do_sample(0, 2000, "R6 lower saturation");
  endtask

  task automatic t_integ();
    set_gains(1049, 98, 1638, 3277, 410);
    do_sample(2048, 900, "R4 accumulate 1");
    do_sample(2048, 900, "R4 accumulate 2");
    do_sample(2048, 1024, "R4 zero error shows integ");
    set_gains(1049, 98, 1638, 100, 410);
    do_sample(2048, 900, "R4 gated out of band");
    do_sample(2048, 1024, "R4 integ held");
    // negative outer error with integrator holding: outer slope sign
    do_sample(0, 1200, "R3 negative outer with integ held");
  endtask

  task automatic t_clamp();
    set_gains(1049, 98, 1638, 3277, 32767);
    do_sample(2048, 524, "R5 drive high");
    do_sample(2048, 1024, "R5 upper clamp");
    do_sample(2048, 1524, "R5 drive low");
    do_sample(2048, 1024, "R5 lower clamp");
  endtask

  task automatic t_latency();
    longint exp_c;
    logic [7:0] held;
    set_gains(1049, 98, 1638, 3277, 0);
    exp_c = model(2400, 1000);
    @(negedge clk); sp = 16'(2400); fb = 12'(1000); sample_vld = 1'b1;
    @(negedge clk); sample_vld = 1'b0;
    @(negedge clk);
    chk(count_vld == 0, "R7 no valid at 2 clocks", longint'(count_vld), 0);
    @(negedge clk);
    chk(count_vld == 1, "R7 valid at 3 clocks", longint'(count_vld), 1);
    chk(longint'(count) == exp_c, "R7 count at valid", longint'(count), exp_c);
    held = count;
    sp = 16'(8000); fb = 12'(0);
    @(negedge clk);
    chk(count_vld == 0, "R7 single-cycle pulse", longint'(count_vld), 0);
    repeat (3) @(negedge clk);
    chk(count == held, "R7 count holds", longint'(count), longint'(held));
  endtask

  task automatic t_mid_reset();
    set_gains(1049, 98, 1638, 3277, 2000);
    do_sample(2048, 900, "R8 prebuild integ");
    do_reset();
    do_sample(2048, 1024, "R8 integ cleared");
  endtask

  initial begin
    set_gains(1049, 98, 1638, 3277, 82);
    repeat (2) @(negedge clk);
    chk(count == 0, "R8 count in reset", longint'(count), 0);
    chk(count_vld == 0, "R8 valid in reset", longint'(count_vld), 0);
    @(negedge clk); rst_ni = 1'b1;
    t_inner();
    t_outer();
    t_saturate();
    do_reset();
    t_integ();
    do_reset();
    t_clamp();
    do_reset();
    t_latency();
    t_mid_reset();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule